// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit processor core and a memory that is one word wide. A store request (address, access size, write data) becomes a 4-bit byte-enable mask and write data moved onto the addressed lanes. A load request takes the addressed byte or halfword out of the word the memory returns, then sign- or zero-extends it to 32 bits. Lane 3 is bits 31:24 and is selected by byte offset 0, so lanes are numbered big-endian.

Misaligned word and halfword accesses do not trap. The block records them in two sticky flags, a read flag and a write flag, and captures the offending address. The access still completes at the address with its low bits forced to zero. The flags are held by a four-state machine. FLT_CLEAN has no flag set. FLT_RD has only the read flag set. FLT_WR has only the write flag set. FLT_BOTH has both flags set. A misaligned read moves CLEAN to RD and WR to BOTH. A misaligned write moves CLEAN to WR and RD to BOTH. BOTH stays in BOTH. A clear pulse first takes the machine back to CLEAN, and a fault arriving in the same cycle is then applied from CLEAN. Any other cycle holds the current state.

The load path and the store path are combinational. The memory's read data is expected in the same cycle as the request. The memory address is always the request address with bits 1:0 cleared.

Top module: `be_lane_aligner`

## Requirements
- R1: A valid word store (size code 2, and code 3 is treated as word) drives mask 4'b1111 with the write data unchanged.
- R2: A valid halfword store (size code 1) with effective address bit 1 clear drives mask 4'b1100 with data[15:0] in bits 31:16. With bit 1 set, it drives mask 4'b0011 with data[15:0] in bits 15:0. Unused lanes carry zero.
- R3: A valid byte store (size code 0) at offsets 0, 1, 2 and 3 drives masks 1000, 0100, 0010 and 0001, with data[7:0] shifted left by 24, 16, 8 and 0 bits. Unused lanes carry zero.
- R4: A word access is misaligned when address bits 1:0 are not 00. A halfword access is misaligned when address bit 0 is 1. A byte access is never misaligned and leaves the flags and the fault address unchanged.
- R5: The cycle after a misaligned read, fault flag bit 0 is set. The cycle after a misaligned write, fault flag bit 1 is set. Both flags stay set until fault_clr is pulsed.
- R6: A misaligned access completes at the forced-aligned address. Its lanes and extraction are those of the address with the low bits zeroed for its size.
- R7: Load extraction is big-endian. Byte offset 0 reads bits 31:24 and offset 3 reads bits 7:0. A halfword with effective bit 1 clear reads bits 31:16, and with it set reads bits 15:0. A word reads all 32 bits.
- R8: With req_signed at 1, a byte or halfword load is sign-extended. With req_signed at 0, it is zero-extended.
- R9: fault_clr empties both flags on the next cycle. If a misaligned access happens in the same cycle as the clear, only that access's flag is set afterwards.
- R10: fault_addr captures the full address of the most recent misaligned access, one cycle later. It is not changed by fault_clr.
- R11: While req_valid is 0, mem_we is 0, mem_be is 0 and no fault is recorded. mem_addr always has bits 1:0 at zero.
- R12: After reset, the flags are 00, fault_addr is 0 and the machine is in FLT_CLEAN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend loaded byte/halfword |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Word read from memory |
| fault_clr | input | 1 | Pulse to empty the sticky fault flags |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| load_data | output | 32 | Extended load result |
| fault_flags | output | 2 | Bit 0 read fault, bit 1 write fault |
| fault_addr | output | 32 | Address of last misaligned access |

## Verification
The hardest situation to reach is the clear pulse arriving in the same cycle as a new misaligned access. Here the clear and the set race for the same flag register. The stimulus first fills both flags, then pulses fault_clr together with a misaligned halfword read. It expects only the read flag afterwards, along with the new fault address. A byte access at an odd address is then sent while the flags are empty, to show that neither the flags nor the fault address move.

// File: rtl/lane_pkg.sv
package lane_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FLT_CLEAN = 2'd0,
        FLT_RD    = 2'd1,
        FLT_WR    = 2'd2,
        FLT_BOTH  = 2'd3
    } flt_state_e;
endpackage

// File: rtl/lane_store_steer.sv
module lane_store_steer
    import lane_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  eff_off,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] steered
);
    logic [OFF_W-1:0] lane;
    assign lane = ~eff_off;  // big-endian: offset 0 -> top lane

    always_comb begin
        be      = '0;
        steered = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                be[lane]           = 1'b1;
                steered[8*lane +: 8] = wdata[7:0];
            end
            SZ_HALF: begin
                if (eff_off[1]) begin
                    be            = 4'b0011;
                    steered[15:0] = wdata[15:0];
                end else begin
                    be             = 4'b1100;
                    steered[31:16] = wdata[15:0];
                end
            end
            SZ_WORD, SZ_WRSV: begin
                be      = '1;
                steered = wdata;
            end
        endcase
    end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
    import lane_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  eff_off,
    input  logic              sign_ext,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result
);
    logic [OFF_W-1:0] lane;
    logic [7:0]       byte_v;
    logic [15:0]      half_v;

    assign lane   = ~eff_off;
    assign byte_v = rdata[8*lane +: 8];
    assign half_v = eff_off[1] ? rdata[15:0] : rdata[31:16];

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: result = {{(WORD_W-8){sign_ext & byte_v[7]}}, byte_v};
            SZ_HALF: result = {{(WORD_W-16){sign_ext & half_v[15]}}, half_v};
            SZ_WORD, SZ_WRSV: result = rdata;
        endcase
    end
endmodule

// File: rtl/lane_fault_fsm.sv
module lane_fault_fsm
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fault_clr,
    output logic [1:0]        fault_flags,
    output logic [ADDR_W-1:0] fault_addr
);
    flt_state_e state_q, base_s, state_d;
    logic       misaligned, rd_hit, wr_hit;

    always_comb begin
        unique case (acc_size_e'(req_size))
            SZ_BYTE:          misaligned = 1'b0;
            SZ_HALF:          misaligned = req_addr[0];
            SZ_WORD, SZ_WRSV: misaligned = |req_addr[1:0];
        endcase
        misaligned = misaligned & req_valid;
    end

    assign rd_hit = misaligned & ~req_write;
    assign wr_hit = misaligned & req_write;

    always_comb begin
        base_s  = fault_clr ? FLT_CLEAN : state_q;
        state_d = base_s;
        unique case (base_s)
            FLT_CLEAN: begin
                if (rd_hit)      state_d = FLT_RD;
                else if (wr_hit) state_d = FLT_WR;
            end
            FLT_RD:   if (wr_hit) state_d = FLT_BOTH;
            FLT_WR:   if (rd_hit) state_d = FLT_BOTH;
            FLT_BOTH: state_d = FLT_BOTH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FLT_CLEAN;
            fault_addr <= '0;
        end else begin
            state_q <= state_d;
            if (misaligned) fault_addr <= req_addr;
        end
    end

    always_comb begin
        unique case (state_q)
            FLT_CLEAN: fault_flags = 2'b00;
            FLT_RD:    fault_flags = 2'b01;
            FLT_WR:    fault_flags = 2'b10;
            FLT_BOTH:  fault_flags = 2'b11;
        endcase
    end

    // R5
    rd_fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd1 && req_addr[0]) |=> fault_flags[0]);
    // R5
    wr_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags[1] && !fault_clr) |=> fault_flags[1]);
    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && !req_valid) |=> fault_flags == 2'b00);
    // R4
    byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0 && !fault_clr) |=> ($stable(fault_flags) && $stable(fault_addr)));
endmodule

// File: rtl/be_lane_aligner.sv
module be_lane_aligner
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              fault_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic [31:0]       load_data,
    output logic [1:0]        fault_flags,
    output logic [ADDR_W-1:0] fault_addr
);
    logic [OFF_W-1:0]  eff_off;
    logic [LANES-1:0]  be_s;
    logic [WORD_W-1:0] wd_s;
    logic              do_write;

    // Forced alignment: clear the low bits the access size cannot use.
    always_comb begin
        unique case (acc_size_e'(req_size))
            SZ_BYTE:          eff_off = req_addr[OFF_W-1:0];
            SZ_HALF:          eff_off = {req_addr[1], 1'b0};
            SZ_WORD, SZ_WRSV: eff_off = '0;
        endcase
    end

    assign do_write  = req_valid & req_write;
    assign mem_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_we    = do_write;
    assign mem_be    = do_write ? be_s : '0;
    assign mem_wdata = do_write ? wd_s : '0;

    lane_store_steer u_store (
        .size    (req_size),
        .eff_off (eff_off),
        .wdata   (req_wdata),
        .be      (be_s),
        .steered (wd_s)
    );

    lane_load_extract u_load (
        .size     (req_size),
        .eff_off  (eff_off),
        .sign_ext (req_signed),
        .rdata    (mem_rdata),
        .result   (load_data)
    );

    lane_fault_fsm #(.ADDR_W(ADDR_W)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_addr    (req_addr),
        .fault_clr   (fault_clr),
        .fault_flags (fault_flags),
        .fault_addr  (fault_addr)
    );

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_be == 4'b0000 && !mem_we));
    // R1
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size[1]) |-> (mem_be == 4'b1111 && mem_wdata == req_wdata));
    // R10
    fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fault_addr));
endmodule

// File: tb/test_be_lane_aligner.sv
module test_be_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, fault_clr = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, load_data, fault_addr;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [1:0]  fault_flags;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    be_lane_aligner i_be_lane_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .fault_clr(fault_clr),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .load_data(load_data), .fault_flags(fault_flags), .fault_addr(fault_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic w, input logic [1:0] sz,
                       input logic sg, input logic [31:0] a, input logic [31:0] d,
                       input logic clr);
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz; req_signed = sg;
        req_addr = a; req_wdata = d; fault_clr = clr;
        #1;
    endtask

    task automatic settle;
        @(negedge clk);
        req_valid = 1'b0; fault_clr = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk("R12 flags", {30'd0, fault_flags}, 32'd0);
        chk("R12 fault_addr", fault_addr, 32'd0);
        chk("R11 idle we", {31'd0, mem_we}, 32'd0);
    endtask

    task automatic t_word_store;
        put(1, 1, 2'd2, 0, 32'h0000_0100, 32'hA1B2_C3D4, 0);
        chk("R1 be", {28'd0, mem_be}, 32'hF);
        chk("R1 wdata", mem_wdata, 32'hA1B2_C3D4);
        chk("R11 mem_addr", mem_addr, 32'h100);
        settle();
    endtask

    task automatic t_half_store;
        put(1, 1, 2'd1, 0, 32'h0000_0100, 32'h0000_BEEF, 0);
        chk("R2 be hi", {28'd0, mem_be}, 32'hC);
        chk("R2 wdata hi", mem_wdata, 32'hBEEF_0000);
        put(1, 1, 2'd1, 0, 32'h0000_0102, 32'h0000_BEEF, 0);
        chk("R2 be lo", {28'd0, mem_be}, 32'h3);
        chk("R2 wdata lo", mem_wdata, 32'h0000_BEEF);
        settle();
    endtask

    task automatic t_byte_store;
        for (int k = 0; k < 4; k++) begin
            put(1, 1, 2'd0, 0, 32'h0000_0200 + k, 32'h0000_005A, 0);
            chk("R3 be", {28'd0, mem_be}, 32'h8 >> k);
            chk("R3 wdata", mem_wdata, 32'h5A00_0000 >> (8 * k));
            chk("R11 aligned addr", mem_addr, 32'h200);
        end
        settle();
    endtask

    task automatic t_loads;
        mem_rdata = 32'h811F_7F3C;
        put(1, 0, 2'd0, 1, 32'h10, 0, 0); chk("R8 byte0 signed", load_data, 32'hFFFF_FF81);
        put(1, 0, 2'd0, 0, 32'h10, 0, 0); chk("R8 byte0 unsigned", load_data, 32'h0000_0081);
        put(1, 0, 2'd0, 1, 32'h11, 0, 0); chk("R7 byte1", load_data, 32'h0000_001F);
        put(1, 0, 2'd0, 1, 32'h12, 0, 0); chk("R7 byte2", load_data, 32'h0000_007F);
        put(1, 0, 2'd0, 0, 32'h13, 0, 0); chk("R7 byte3", load_data, 32'h0000_003C);
        put(1, 0, 2'd1, 1, 32'h10, 0, 0); chk("R8 half signed", load_data, 32'hFFFF_811F);
        put(1, 0, 2'd1, 0, 32'h10, 0, 0); chk("R8 half unsigned", load_data, 32'h0000_811F);
        put(1, 0, 2'd1, 1, 32'h12, 0, 0); chk("R7 half lo", load_data, 32'h0000_7F3C);
        put(1, 0, 2'd2, 1, 32'h10, 0, 0); chk("R7 word", load_data, 32'h811F_7F3C);
        settle();
        chk("R4 aligned loads no flag", {30'd0, fault_flags}, 32'd0);
    endtask

    task automatic t_mis_read;
        put(1, 0, 2'd2, 0, 32'h0000_0301, 0, 0);
        chk("R6 mis word read data", load_data, 32'h811F_7F3C);
        chk("R6 mis word addr", mem_addr, 32'h300);
        settle();
        chk("R5 read flag", {30'd0, fault_flags}, 32'h1);
        chk("R10 fault addr", fault_addr, 32'h301);
        put(1, 0, 2'd2, 0, 32'h0000_0400, 0, 0);
        settle();
        chk("R5 sticky", {30'd0, fault_flags}, 32'h1);
        chk("R10 addr held", fault_addr, 32'h301);
    endtask

    task automatic t_mis_write;
        put(1, 1, 2'd1, 0, 32'h0000_0405, 32'h0000_1234, 0);
        chk("R6 mis half be", {28'd0, mem_be}, 32'hC);
        chk("R6 mis half wdata", mem_wdata, 32'h1234_0000);
        settle();
        chk("R5 both flags", {30'd0, fault_flags}, 32'h3);
        chk("R10 write addr", fault_addr, 32'h405);
    endtask

    task automatic t_clear_race;
        put(1, 0, 2'd1, 1, 32'h0000_0503, 0, 1);
        chk("R6 mis half read", load_data, 32'h0000_7F3C);
        settle();
        chk("R9 clear+fault", {30'd0, fault_flags}, 32'h1);
        chk("R10 race addr", fault_addr, 32'h503);
        put(0, 0, 2'd0, 0, 0, 0, 1);
        settle();
        chk("R9 clear", {30'd0, fault_flags}, 32'h0);
        chk("R10 clear keeps addr", fault_addr, 32'h503);
    endtask

    task automatic t_byte_and_idle;
        put(1, 1, 2'd0, 0, 32'h0000_0607, 32'h0000_0011, 0);
        settle();
        chk("R4 byte odd flags", {30'd0, fault_flags}, 32'h0);
        chk("R4 byte odd addr", fault_addr, 32'h503);
        put(0, 1, 2'd2, 0, 32'h0000_0703, 32'hFFFF_FFFF, 0);
        chk("R11 idle be", {28'd0, mem_be}, 32'h0);
        chk("R11 idle we", {31'd0, mem_we}, 32'h0);
        settle();
        chk("R11 idle no fault", {30'd0, fault_flags}, 32'h0);
    endtask

    initial begin
        #10;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_word_store();
        t_half_store();
        t_byte_store();
        t_loads();
        t_mis_read();
        t_mis_write();
        t_clear_race();
        t_byte_and_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule